// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Load Logic

This block holds the digital words for a two-channel, 12-bit converter. A processor reaches it over an 8-bit parallel bus with a 2-bit address, and it fills each channel's 12-bit holding register in two writes: one for the low eight bits and one for the top four. The data is right-justified, so the top four bits arrive on the lowest bus lines.

A separate update strobe copies both holding registers into the output registers on the same clock edge. The output registers feed the two conversion ladders. Software can therefore prepare both channels one byte at a time and make them change together. An active-low clear line sets every register in the block to zero at once, with no clock needed. All bus strobes are active low and are sampled on a system clock. Each write or update acts once, on the first edge where its condition is seen.

Top module: `dual_dac_loader`

## Requirements
- R1: The address picks the target part. Bit 1 picks the channel (0 = channel A, 1 = channel B). Bit 0 picks the part (0 = low eight bits, 1 = high four bits). So 00 is A low, 01 is A high, 10 is B low and 11 is B high.
- R2: A holding register part is written only on an edge where csN and wrN are both sampled low. Otherwise the holding registers keep their contents.
- R3: A high-part write takes word bits [11:8] from bus bits [3:0]. Bus bits [7:4] have no effect.
- R4: Writing one part of a word leaves the other part of that holding register unchanged.
- R5: On an edge where updN and wrN are both sampled low, both output registers load their holding registers together. csN has no effect on the update.
- R6: The output registers change only on an update edge or through a clear.
- R7: A strobe condition that stays true acts only on its first edge. A write with a held strobe is not repeated with later bus data, and a held update does not transfer again.
- R8: When csN, wrN and updN are all low on the same edge, the write is applied first. The update then moves the newly written word, and the output shows it after that same edge.
- R9: Taking clrN low clears every holding and output register of both channels to zero at once, without waiting for a clock edge.
- R10: While clrN is low, no write or update takes effect, even if its strobes are active.
- R11: The output ports show the new value right after the clock edge that performs the transfer, with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| clrN | input | 1 | Asynchronous active-low clear of all registers |
| addr | input | 2 | Target select: bit 1 is the channel, bit 0 is the part |
| busData | input | 8 | Parallel data bus |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| updN | input | 1 | Active-low update strobe, used together with wrN |
| chanAOut | output | 12 | Channel A output register |
| chanBOut | output | 12 | Channel B output register |

## Verification
Directed sequences load distinct bit patterns into all four address targets, so a swapped channel or part select shows up as a wrong nibble or byte. A high-part write with junk in bus bits [7:4] exposes any leak of the upper bus lines. Held strobes with changing bus data separate edge-triggered from level-triggered behaviour. A combined write-and-update, and clears applied while strobes are active, test the ordering and priority rules. A long random run then mixes all strobes and addresses with occasional clears, and every cycle is compared against a bench model of the requirements.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  parameter int CH_COUNT = 2;
  parameter int WORD_W   = 12;
  parameter int BUS_W    = 8;
  parameter int LO_W     = BUS_W;
  parameter int HI_W     = WORD_W - LO_W;
  parameter int CH_SEL_W = $clog2(CH_COUNT);
  parameter int ADDR_W   = CH_SEL_W + 1;

  typedef struct packed {
    logic [CH_COUNT-1:0] loadLo;
    logic [CH_COUNT-1:0] loadHi;
    logic                xfer;
  } ldStrobe_t;
endpackage

// File: rtl/dacld_ctrl.sv
module dacld_ctrl
  import dacld_pkg::*;
(
  input  logic              clk,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              csN,
  input  logic              wrN,
  input  logic              updN,
  output ldStrobe_t         strb
);
  logic wrCond, updCond;
  logic wrSeen, updSeen;
  logic wrFire, updFire;

  assign wrCond  = ~csN & ~wrN;
  assign updCond = ~updN & ~wrN;
  assign wrFire  = wrCond & ~wrSeen;
  assign updFire = updCond & ~updSeen;

  // remember last sampled conditions so a held strobe acts once
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      wrSeen  <= 1'b0;
      updSeen <= 1'b0;
    end else begin
      wrSeen  <= wrCond;
      updSeen <= updCond;
    end
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_dec
    logic chHit;
    assign chHit              = (addr[ADDR_W-1:1] == CH_SEL_W'(ch));
    assign strb.loadLo[ch]    = wrFire & chHit & ~addr[0];
    assign strb.loadHi[ch]    = wrFire & chHit &  addr[0];
  end

  assign strb.xfer = updFire;
endmodule

// File: rtl/dacld_datapath.sv
module dacld_datapath
  import dacld_pkg::*;
(
  input  logic                             clk,
  input  logic                             clrN,
  input  logic [BUS_W-1:0]                 busData,
  input  ldStrobe_t                        strb,
  output logic [CH_COUNT-1:0][WORD_W-1:0]  chanWord
);
  logic [BUS_W-HI_W-1:0] unusedBusTop;
  assign unusedBusTop = busData[BUS_W-1:HI_W];

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    logic [WORD_W-1:0] holdReg;
    logic [WORD_W-1:0] holdNext;
    logic [WORD_W-1:0] outReg;

    always_comb begin
      holdNext = holdReg;
      if (strb.loadLo[ch]) holdNext[LO_W-1:0]      = busData[LO_W-1:0];
      if (strb.loadHi[ch]) holdNext[WORD_W-1:LO_W] = busData[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        holdReg <= '0;
        outReg  <= '0;
      end else begin
        holdReg <= holdNext;
        if (strb.xfer) outReg <= holdNext;
      end
    end

    assign chanWord[ch] = outReg;
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacld_pkg::*;
(
  input  logic              clk,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  busData,
  input  logic              csN,
  input  logic              wrN,
  input  logic              updN,
  output logic [WORD_W-1:0] chanAOut,
  output logic [WORD_W-1:0] chanBOut
);
  ldStrobe_t                       strb;
  logic [CH_COUNT-1:0][WORD_W-1:0] chanWord;

  dacld_ctrl ctrl_i (
    .clk   (clk),
    .clrN  (clrN),
    .addr  (addr),
    .csN   (csN),
    .wrN   (wrN),
    .updN  (updN),
    .strb  (strb)
  );

  dacld_datapath dp_i (
    .clk      (clk),
    .clrN     (clrN),
    .busData  (busData),
    .strb     (strb),
    .chanWord (chanWord)
  );

  assign chanAOut = chanWord[0];
  assign chanBOut = chanWord[1];
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker
  import dacld_pkg::*;
(
  input logic              clk,
  input logic              clrN,
  input logic              wrN,
  input logic              updN,
  input logic [WORD_W-1:0] chanAOut,
  input logic [WORD_W-1:0] chanBOut
);
  logic armed;
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R6: an output move needs an update condition on the edge before
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!clrN)
    (armed && (chanAOut != $past(chanAOut) || chanBOut != $past(chanBOut)))
      |-> $past(!updN && !wrN));

  // R7: a held update condition does not transfer again
  p_upd_once_r7: assert property (@(posedge clk) disable iff (!clrN)
    (armed && $past(!updN && !wrN) && !updN && !wrN)
      |=> ($stable(chanAOut) && $stable(chanBOut)));

  // R9: outputs read zero whenever clear is low
  p_clr_zero_r9: assert property (@(posedge clk)
    !clrN |-> (chanAOut == '0 && chanBOut == '0));

  // R10: nothing got through while clear was held
  p_clr_exit_r10: assert property (@(posedge clk) disable iff (!clrN)
    $past(!clrN) |-> (chanAOut == '0 && chanBOut == '0));
endmodule

bind dual_dac_loader dacld_checker chk_i (
  .clk      (clk),
  .clrN     (clrN),
  .wrN      (wrN),
  .updN     (updN),
  .chanAOut (chanAOut),
  .chanBOut (chanBOut)
);

// File: tb/dual_dac_loader_tb_top.sv
module dual_dac_loader_tb_top;
  logic        clk = 1'b0;
  logic        clrN = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  busData = 8'h00;
  logic        csN = 1'b1;
  logic        wrN = 1'b1;
  logic        updN = 1'b1;
  logic [11:0] chanAOut, chanBOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [11:0] expIn [2];
  logic [11:0] expOut [2];
  logic        prevWr, prevUpd;

  always #5 clk = ~clk;

  dual_dac_loader dut_i (
    .clk(clk), .clrN(clrN), .addr(addr), .busData(busData),
    .csN(csN), .wrN(wrN), .updN(updN),
    .chanAOut(chanAOut), .chanBOut(chanBOut)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelClear();
    expIn[0] = '0; expIn[1] = '0; expOut[0] = '0; expOut[1] = '0;
    prevWr = 1'b0; prevUpd = 1'b0;
  endfunction

  // one bus cycle: drive at negedge, model at posedge, compare just after
  task automatic step(input logic [1:0] a, input logic [7:0] d,
                      input logic cs, input logic wr, input logic upd, input string tag);
    logic wc, uc;
    @(negedge clk);
    addr = a; busData = d; csN = cs; wrN = wr; updN = upd;
    @(posedge clk);
    if (clrN) begin
      wc = !cs && !wr;
      uc = !upd && !wr;
      if (wc && !prevWr) begin
        if (a[0]) expIn[a[1]][11:8] = d[3:0];
        else      expIn[a[1]][7:0]  = d;
      end
      if (uc && !prevUpd) begin
        expOut[0] = expIn[0];
        expOut[1] = expIn[1];
      end
      prevWr = wc;
      prevUpd = uc;
    end else begin
      modelClear();
    end
    #1;
    check(tag, chanAOut, expOut[0]);
    check(tag, chanBOut, expOut[1]);
  endtask

  task automatic idle(input string tag);
    step(2'b00, 8'h00, 1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic setClear(input logic v);
    @(negedge clk);
    clrN = v;
    if (!v) begin
      modelClear();
      #1;
      check("R9 async clear", chanAOut, 12'h000);
      check("R9 async clear", chanBOut, 12'h000);
    end
  endtask

  initial begin
    modelClear();
    void'($urandom(32'd20240611));
    #1;
    check("R9 reset state", chanAOut, 12'h000);
    check("R9 reset state", chanBOut, 12'h000);
    setClear(1'b1);
    idle("R6 idle");

    // R1 R3: fill all four targets, junk in upper bus bits of high parts
    step(2'b00, 8'h5A, 1'b0, 1'b0, 1'b1, "R1 A low");
    idle("R6 no update");
    step(2'b01, 8'hF3, 1'b0, 1'b0, 1'b1, "R3 A high");
    idle("R6 no update");
    step(2'b10, 8'h11, 1'b0, 1'b0, 1'b1, "R1 B low");
    idle("R6 no update");
    step(2'b11, 8'hAC, 1'b0, 1'b0, 1'b1, "R3 B high");
    check("R6 held before update", chanAOut, 12'h000);
    // R5 R11: update with csN high, both move on this edge
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b0, "R5 update");
    check("R5 R11 A after update", chanAOut, 12'h35A);
    check("R5 R11 B after update", chanBOut, 12'hC11);
    idle("R6 idle");

    // R4: low part only
    step(2'b00, 8'hFF, 1'b0, 1'b0, 1'b1, "R4 A low only");
    idle("R6 idle");
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b0, "R4 update");
    check("R4 high part kept", chanAOut, 12'h3FF);

    // R2: partial strobes do nothing
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b1, "R2 cs high");
    step(2'b00, 8'h00, 1'b0, 1'b1, 1'b1, "R2 wr high");
    idle("R6 idle");
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b0, "R2 update");
    check("R2 no write", chanAOut, 12'h3FF);
    idle("R6 idle");

    // R7: held write with changing data, then held update
    step(2'b10, 8'h77, 1'b0, 1'b0, 1'b1, "R7 first write");
    step(2'b10, 8'h88, 1'b0, 1'b0, 1'b1, "R7 held write");
    idle("R6 idle");
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b0, "R7 update");
    check("R7 write once", chanBOut, 12'hC77);
    step(2'b11, 8'h05, 1'b0, 1'b0, 1'b0, "R7 held update");
    check("R7 update once", chanBOut, 12'hC77);
    idle("R6 idle");

    // R8: write and update together
    step(2'b01, 8'h0A, 1'b0, 1'b0, 1'b0, "R8 combined");
    check("R8 new value moved", chanAOut, 12'hAFF);
    check("R8 B from held write", chanBOut, 12'h577);
    idle("R6 idle");

    // R10: clear beats active strobes
    step(2'b00, 8'h12, 1'b0, 1'b0, 1'b0, "R10 pre");
    setClear(1'b0);
    step(2'b10, 8'h34, 1'b0, 1'b0, 1'b0, "R10 during clear");
    step(2'b01, 8'h0F, 1'b0, 1'b0, 1'b0, "R10 during clear");
    step(2'b00, 8'h00, 1'b1, 1'b1, 1'b1, "R10 strobes off");
    setClear(1'b1);
    step(2'b00, 8'h00, 1'b1, 1'b0, 1'b0, "R10 update after clear");
    check("R10 A zero", chanAOut, 12'h000);
    check("R10 B zero", chanBOut, 12'h000);
    idle("R6 idle");

    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 50) == 0) begin
        setClear(1'b0);
        step(2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R10 random clear");
        idle("R9 random clear");
        setClear(1'b1);
      end
      step(2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule